// File: doc/BRIEF.md
# Prescaled Timer with Keyed Watchdog

The block is a register-mapped timer. A programmable prescaler produces count ticks from the bus clock. The tick drives a counter built from two 32-bit halves. Each half has its own period register and its own release bit. In the chained modes the halves act as one 64-bit counter that compares against one 64-bit period. In the split modes each half wraps at its own period. A two-bit run field starts and stops counting.

In watchdog mode the block becomes a keyed supervisor. Software arms it with an ordered 16-bit key in the upper half of the watchdog word. Software services it with that key followed by a second key, which clears the 64-bit count. Any other key restarts the sequence and clears nothing. Once armed, the configuration is locked until system reset. When the armed count meets the period, the block raises a single-cycle reset request and holds the count there until the next valid service.

All registers sit on a simple bus: a write strobe, a 3-bit word index, write data, and a combinational read path.

Top module: `keyed_wd_timer`

## Requirements
- R1: After reset every register reads zero and `reset_req` is low; a reset also disarms the watchdog.
- R2: The prescaler field at control-word bits 11:8 holds d. While running, the counter advances once every d+1 clocks, so after N clocks of running it has advanced floor(N/(d+1)).
- R3: The run field at bits 23:22 of the run word (index 4) starts counting with value 2. The values 0, 1 and 3 freeze both counters at their present value.
- R4: Mode field bits 3:2 of the control word (index 5) set to 1 or 3 selects split operation. Each half wraps to zero on the tick after it equals its own period. A half whose release bit is clear is held at zero; the release bit is bit 0 for the low half and bit 1 for the high half.
- R5: Mode 0, and mode 2 while disarmed, select chained operation. The 64-bit count {high, low} carries from the low half into the high half and wraps to zero on the tick after it equals the 64-bit period {PER_HI, PER_LO}. The count is held at zero unless both release bits are set.
- R6: Counter words read their live value, and a write loads the written value, while the watchdog is disarmed.
- R7: The watchdog word (index 6) takes a key in bits 31:16 and an enable flag in bit 14. Writing key 0xA5C6 with bit 14 set, while the mode is 2, arms the watchdog. Bit 14 reads back as the armed state; all other bits read 0.
- R8: In mode 2, a write with key 0xDA7E that directly follows a key-0xA5C6 write clears the 64-bit count and the expiry hold. When d = 0, the count then reads n after n further clocks.
- R9: A key 0xDA7E that is not directly preceded by 0xA5C6 clears nothing. A write with any other key sends the sequence back to waiting for 0xA5C6.
- R10: Once armed, the watchdog cannot be disarmed by software. Writes to the counter, period, run and control words are ignored.
- R11: When the armed count equals the period, `reset_req` goes high for exactly one clock, one cycle later. The count then holds at the period with no further request until it is serviced.
- R12: The word map is: 0 low count, 1 high count, 2 low period, 3 high period, 4 run word, 5 control word, 6 watchdog word. Index 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The prescaler is swept over every divide value from 0 to 15, with the count after a fixed run length compared against floor(N/(d+1)); this separates off-by-one tick spacing from a wrong field position. Cycle-exact sequences compare wrap points in chained and split modes: a 64-bit period that forces a carry across the halves, split periods of different lengths, and each release-bit combination, so that a carry bug, a shared-period bug and a release-bit mix-up each give a distinct wrong value. The key sequence is driven with the service key alone, a wrong key between the two keys, the arming key without the enable flag, and the proper pair. An expiry run then checks that the reset request falls on exactly one cycle after the period is reached and that the count stays held afterwards.

// File: rtl/kwt_pkg.sv
package kwt_pkg;

  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_SVC = 16'hDA7E;

  localparam logic [2:0] IDX_CNT_LO = 3'd0;
  localparam logic [2:0] IDX_CNT_HI = 3'd1;
  localparam logic [2:0] IDX_PER_LO = 3'd2;
  localparam logic [2:0] IDX_PER_HI = 3'd3;
  localparam logic [2:0] IDX_RUN    = 3'd4;
  localparam logic [2:0] IDX_CTRL   = 3'd5;
  localparam logic [2:0] IDX_WDOG   = 3'd6;

  localparam logic [1:0] RUN_CONT = 2'd2;

  typedef enum logic [1:0] {
    MODE_CHAIN     = 2'd0,
    MODE_SPLIT     = 2'd1,
    MODE_WDOG      = 2'd2,
    MODE_SPLIT_ALT = 2'd3
  } tmode_e;

  typedef enum logic {
    KS_WANT_FIRST  = 1'b0,
    KS_WANT_SECOND = 1'b1
  } key_state_e;

endpackage

// File: rtl/kwt_prescaler.sv
module kwt_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] phase;

  // the tick fires on the clock where the phase has used up the ratio
  function automatic logic f_due(input logic [PSC_W-1:0] ph, input logic [PSC_W-1:0] lim);
    return ph >= lim;
  endfunction

  assign tick = run && !clr && f_due(phase, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (!run || clr)       phase <= '0;
    else if (f_due(phase, div)) phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  assert_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == '0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tick) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/kwt_counter.sv
module kwt_counter
  import kwt_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              rel_lo,
  input  logic              rel_hi,
  input  logic              tick,
  input  logic              armed,
  input  logic              clr,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  input  logic [HALF_W-1:0] per_lo,
  input  logic [HALF_W-1:0] per_hi,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              at_period
);

  localparam int CW = 2 * HALF_W;

  function automatic logic [HALF_W-1:0] f_wrap_half(input logic [HALF_W-1:0] cur,
                                                     input logic [HALF_W-1:0] per);
    return (cur == per) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [CW-1:0] f_wrap_full(input logic [CW-1:0] cur, input logic [CW-1:0] per);
    return (cur == per) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [CW-1:0] f_sat_full(input logic [CW-1:0] cur, input logic [CW-1:0] per);
    return (cur == per) ? cur : cur + 1'b1;
  endfunction

  logic              chained;
  logic [CW-1:0]     cnt_full;
  logic [CW-1:0]     per_full;
  logic [CW-1:0]     step_full;
  logic [HALF_W-1:0] nxt_lo;
  logic [HALF_W-1:0] nxt_hi;

  assign chained   = (mode == MODE_CHAIN) || (mode == MODE_WDOG);
  assign cnt_full  = {cnt_hi, cnt_lo};
  assign per_full  = {per_hi, per_lo};
  assign at_period = (cnt_full == per_full);
  assign step_full = armed ? f_sat_full(cnt_full, per_full) : f_wrap_full(cnt_full, per_full);

  always_comb begin
    nxt_lo = cnt_lo;
    nxt_hi = cnt_hi;
    if (clr) begin
      nxt_lo = '0;
      nxt_hi = '0;
    end else if (chained) begin
      if (!armed && !(rel_lo && rel_hi)) begin
        nxt_lo = '0;
        nxt_hi = '0;
      end else begin
        if (tick) {nxt_hi, nxt_lo} = step_full;
        if (ld_lo) nxt_lo = ld_data;
        if (ld_hi) nxt_hi = ld_data;
      end
    end else begin
      if (!rel_lo)    nxt_lo = '0;
      else if (ld_lo) nxt_lo = ld_data;
      else if (tick)  nxt_lo = f_wrap_half(cnt_lo, per_lo);
      if (!rel_hi)    nxt_hi = '0;
      else if (ld_hi) nxt_hi = ld_data;
      else if (tick)  nxt_hi = f_wrap_half(cnt_hi, per_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= nxt_lo;
      cnt_hi <= nxt_hi;
    end
  end

  assert_service_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_lo == '0 && cnt_hi == '0));

  assert_hold_at_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && at_period && !clr) |=> at_period);

  assert_frozen_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !ld_lo && !ld_hi && rel_lo && rel_hi) |=> $stable({cnt_hi, cnt_lo}));

  assert_split_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chained && rel_lo && tick && !ld_lo && !clr && cnt_lo == per_lo) |=> (cnt_lo == '0));

endmodule

// File: rtl/kwt_keyfsm.sv
module kwt_keyfsm
  import kwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wd_wr,
  input  logic [15:0] wd_key,
  input  logic        wd_en_bit,
  input  logic        mode_is_wd,
  output logic        armed,
  output logic        svc_clr
);

  key_state_e state;
  logic       key_is_arm;
  logic       key_is_svc;

  assign key_is_arm = (wd_key == KEY_ARM);
  assign key_is_svc = (wd_key == KEY_SVC);
  assign svc_clr    = wd_wr && key_is_svc && (state == KS_WANT_SECOND) && mode_is_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KS_WANT_FIRST;
      armed <= 1'b0;
    end else if (wd_wr) begin
      if (key_is_arm) begin
        state <= KS_WANT_SECOND;
        if (wd_en_bit && mode_is_wd) armed <= 1'b1;
      end else begin
        state <= KS_WANT_FIRST;
      end
    end
  end

  assert_armed_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_wrong_key_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wr && !key_is_arm && !key_is_svc) |=> (state == KS_WANT_FIRST));

  assert_arm_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wr && key_is_arm && wd_en_bit && mode_is_wd) |=> (armed && state == KS_WANT_SECOND));

endmodule

// File: rtl/keyed_wd_timer.sv
module keyed_wd_timer
  import kwt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);

  localparam int HALF_W  = DATA_W;
  localparam int PSC_LSB = 8;
  localparam int RUN_LSB = 22;
  localparam int KEY_LSB = 16;
  localparam int WEN_BIT = 14;

  logic [HALF_W-1:0] per_lo, per_hi;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic [1:0]        run_field;
  logic [PSC_W-1:0]  psc_div;
  logic              rel_lo, rel_hi;
  tmode_e            mode;
  logic              armed, svc_clr, tick, at_period;
  logic              expired, expiry_hit;
  logic              cfg_wr, wd_wr, ld_lo, ld_hi, run_en;

  assign cfg_wr = bus_wr && !armed;
  assign wd_wr  = bus_wr && (bus_addr == IDX_WDOG);
  assign ld_lo  = cfg_wr && (bus_addr == IDX_CNT_LO);
  assign ld_hi  = cfg_wr && (bus_addr == IDX_CNT_HI);
  assign run_en = armed || (run_field == RUN_CONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_lo    <= '0;
      per_hi    <= '0;
      run_field <= '0;
      psc_div   <= '0;
      rel_lo    <= 1'b0;
      rel_hi    <= 1'b0;
      mode      <= MODE_CHAIN;
    end else if (cfg_wr) begin
      case (bus_addr)
        IDX_PER_LO: per_lo    <= bus_wdata;
        IDX_PER_HI: per_hi    <= bus_wdata;
        IDX_RUN:    run_field <= bus_wdata[RUN_LSB +: 2];
        IDX_CTRL: begin
          rel_lo  <= bus_wdata[0];
          rel_hi  <= bus_wdata[1];
          mode    <= tmode_e'(bus_wdata[3:2]);
          psc_div <= bus_wdata[PSC_LSB +: PSC_W];
        end
        default: ;
      endcase
    end
  end

  kwt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_en),
    .clr  (svc_clr),
    .div  (psc_div),
    .tick (tick)
  );

  kwt_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .rel_lo   (rel_lo),
    .rel_hi   (rel_hi),
    .tick     (tick),
    .armed    (armed),
    .clr      (svc_clr),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .ld_data  (bus_wdata),
    .per_lo   (per_lo),
    .per_hi   (per_hi),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .at_period(at_period)
  );

  kwt_keyfsm u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_wr     (wd_wr),
    .wd_key    (bus_wdata[KEY_LSB +: 16]),
    .wd_en_bit (bus_wdata[WEN_BIT]),
    .mode_is_wd(mode == MODE_WDOG),
    .armed     (armed),
    .svc_clr   (svc_clr)
  );

  // expiry: one request per period match, then latched until a service
  assign expiry_hit = armed && at_period && !expired && !svc_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expired   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= expiry_hit;
      if (svc_clr)         expired <= 1'b0;
      else if (expiry_hit) expired <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_CNT_LO: bus_rdata = cnt_lo;
      IDX_CNT_HI: bus_rdata = cnt_hi;
      IDX_PER_LO: bus_rdata = per_lo;
      IDX_PER_HI: bus_rdata = per_hi;
      IDX_RUN:    bus_rdata[RUN_LSB +: 2] = run_field;
      IDX_CTRL: begin
        bus_rdata[0]                 = rel_lo;
        bus_rdata[1]                 = rel_hi;
        bus_rdata[3:2]               = mode;
        bus_rdata[PSC_LSB +: PSC_W]  = psc_div;
      end
      IDX_WDOG:   bus_rdata[WEN_BIT] = armed;
      default:    bus_rdata = '0;
    endcase
  end

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  assert_request_needs_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (armed && expired));

  assert_config_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr) |=> ($stable(per_lo) && $stable(per_hi) && $stable(run_field) && $stable(mode)));

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !reset_req);

endmodule

// File: tb/sim_keyed_wd_timer.sv
module sim_keyed_wd_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_wd_timer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = idx; bus_wdata = data;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] idx, output logic [31:0] v);
    bus_addr = idx; #1 v = bus_rdata;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    peek(idx, v);
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    @(negedge clk);
    peek(3'd0, lo);
    peek(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setup(input logic [31:0] ctrl, input logic [63:0] per, input logic [63:0] start);
    wr(3'd4, 32'd0);
    wr(3'd5, ctrl);
    wr(3'd2, per[31:0]);
    wr(3'd3, per[63:32]);
    wr(3'd0, start[31:0]);
    wr(3'd1, start[63:32]);
  endtask

  localparam logic [31:0] RUN_GO = 32'h0080_0000;

  initial begin
    logic [31:0] v, c1, c2;
    logic [63:0] v64, exp64;
    int pulses;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R12: reset state over the whole map
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check($sformatf("R1 reset idx %0d", i), v, 0);
    end
    check("R1 reset_req low", reset_req, 0);

    // R12 / R6: map and readback
    setup(32'h0000_0003, 64'h0000_00AB_0000_00CD, 64'h1234_5678_9ABC_DEF0);
    rd(3'd2, v); check("R12 period low word", v, 32'hCD);
    rd(3'd3, v); check("R12 period high word", v, 32'hAB);
    rd(3'd5, v); check("R12 control word", v, 32'h3);
    rd(3'd0, v); check("R6 count low load", v, 32'h9ABC_DEF0);
    rd(3'd1, v); check("R6 count high load", v, 32'h1234_5678);

    // R2: sweep of the whole prescaler field, R3 freeze after stop
    for (int d = 0; d < 16; d++) begin
      setup(32'(d << 8) | 32'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      wr(3'd4, RUN_GO);
      repeat (50) @(posedge clk);
      rd(3'd0, v);
      check($sformatf("R2 div %0d count", d), v, 32'(50 / (d + 1)));
    end

    // R3: every non-run value freezes
    for (int e = 0; e < 4; e++) begin
      if (e == 2) continue;
      setup(32'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      wr(3'd4, RUN_GO);
      repeat (7) @(posedge clk);
      wr(3'd4, 32'(e << 22));
      rd(3'd0, c1);
      repeat (9) @(posedge clk);
      rd(3'd0, c2);
      check($sformatf("R3 run field %0d frozen", e), c2, c1);
      check($sformatf("R3 run field %0d had counted", e), (c1 != 0), 1);
    end

    // R5: chained carry across halves and 64-bit wrap
    setup(32'h3, 64'h0000_0001_0000_0001, 64'h0000_0000_FFFF_FFFE);
    wr(3'd4, RUN_GO);
    for (int i = 0; i < 9; i++) begin
      rd64(v64);
      exp64 = (64'h0000_0000_FFFF_FFFE + 64'(i)) % 64'h0000_0001_0000_0002;
      check($sformatf("R5 chained step %0d", i), v64, exp64);
    end

    // R5: short chained period, and mode 2 while disarmed behaves alike
    for (int m = 0; m < 2; m++) begin
      setup(m == 0 ? 32'h3 : 32'hB, 64'd5, 64'd0);
      wr(3'd4, RUN_GO);
      for (int i = 0; i < 14; i++) begin
        rd64(v64);
        check($sformatf("R5 mode %0d wrap step %0d", m * 2, i), v64, 64'(i % 6));
      end
    end

    // R5: one release bit missing holds the chained count at zero
    setup(32'h1, 64'd100, 64'd0);
    wr(3'd4, RUN_GO);
    repeat (10) @(posedge clk);
    rd64(v64);
    check("R5 chained held without both release bits", v64, 0);

    // R4: split modes, each release combination
    for (int m = 1; m < 4; m += 2) begin
      for (int r = 1; r < 4; r++) begin
        setup(32'(m << 2) | 32'(r), 64'h0000_0003_0000_0002, 64'd0);
        wr(3'd4, RUN_GO);
        for (int i = 0; i < 13; i++) begin
          rd64(v64);
          exp64[31:0]  = r[0] ? 32'(i % 3) : 32'd0;
          exp64[63:32] = r[1] ? 32'(i % 4) : 32'd0;
          check($sformatf("R4 mode %0d rel %0d step %0d", m, r, i), v64, exp64);
        end
      end
    end

    // R9 / R8: key sequence while disarmed and stopped, mode 2
    setup(32'hB, 64'd200, 64'd7);
    wr(3'd6, 32'hDA7E_4000);
    rd(3'd0, v); check("R9 lone service key clears nothing", v, 7);
    wr(3'd6, 32'hA5C6_0000);
    rd(3'd6, v); check("R7 no arm without enable bit", v, 0);
    wr(3'd6, 32'h1234_0000);
    wr(3'd6, 32'hDA7E_0000);
    rd(3'd0, v); check("R9 wrong key between the pair", v, 7);
    wr(3'd6, 32'hA5C6_0000);
    wr(3'd6, 32'hDA7E_0000);
    rd(3'd0, v); check("R8 ordered pair clears count", v, 0);

    // R7: arm
    wr(3'd0, 32'd7);
    wr(3'd4, RUN_GO);
    wr(3'd6, 32'hA5C6_4000);
    rd(3'd6, v); check("R7 armed reads back", v, 32'h0000_4000);

    // R10: locked configuration
    wr(3'd4, 32'd0);
    rd(3'd4, v); check("R10 run word locked", v, RUN_GO);
    wr(3'd5, 32'd0);
    rd(3'd5, v); check("R10 control word locked", v, 32'hB);
    wr(3'd2, 32'd5);
    rd(3'd2, v); check("R10 period locked", v, 32'd200);
    wr(3'd6, 32'h0000_0000);
    rd(3'd6, v); check("R10 cannot disarm", v, 32'h0000_4000);
    wr(3'd0, 32'hFFFF_0000);
    rd(3'd0, v); check("R10 count load ignored", (v <= 32'd200), 1);

    // R8 / R11: service, then exact expiry timing
    wr(3'd6, 32'hA5C6_4000);
    wr(3'd6, 32'hDA7E_4000);
    bus_addr = 3'd0;
    pulses = 0;
    for (int n = 0; n < 260; n++) begin
      @(negedge clk);
      #1;
      if (reset_req) pulses++;
      if (n < 5) check($sformatf("R8 count after service n=%0d", n), bus_rdata, 32'(n));
      if (n == 200 || n == 201 || n == 202)
        check($sformatf("R11 request at n=%0d", n), reset_req, (n == 201));
    end
    check("R11 exactly one request", pulses, 1);
    rd64(v64); check("R11 count held at period", v64, 64'd200);

    // R8: service after expiry restarts from zero
    wr(3'd6, 32'hA5C6_4000);
    wr(3'd6, 32'hDA7E_4000);
    rd(3'd0, v); check("R8 service after expiry", v, 0);
    check("R11 no request after service", reset_req, 0);

    // R9: wrong key while armed leaves the count running
    repeat (50) @(posedge clk);
    rd(3'd0, c1);
    wr(3'd6, 32'hA5C6_4000);
    wr(3'd6, 32'h1234_4000);
    wr(3'd6, 32'hDA7E_4000);
    rd(3'd0, c2);
    check("R9 armed wrong key, no clear", (c2 > c1), 1);

    // R1: reset disarms and clears
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), v);
      check($sformatf("R1 after reset idx %0d", i), v, 0);
    end
    check("R1 reset_req after reset", reset_req, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not complete, got hang expected end");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule